// File: doc/BRIEF.md
# Short Packet Capture Queue

This block collects short packets from a camera receive path (frame start and end, line start and end, and generic short packets) into a small first-in first-out queue. The upstream packet decoder presents one strobe per packet together with its 6-bit data type, 2-bit virtual channel and 16-bit data field. Software drains the queue through a single data register. Each read of that register removes the oldest entry.

The block drives a full flag and a not-empty flag for the status register. It also drives two event lines toward an interrupt block. The not-empty event is pending while entries are queued. When software clears it, it drops for one cycle and comes back on the next cycle if entries remain. Software can therefore drain the queue by reading and clearing until the event stays low. A packet that arrives with no free slot is discarded, and a sticky overflow event is raised.

Top module: `spkt_queue`

## Requirements
- R1: The queue holds DEPTH entries (default 31) in arrival order, and `sts_full` is high exactly when DEPTH entries are held.
- R2: A read word carries the data field in bits 23:8, the virtual channel in bits 7:6 and the data type in bits 5:0, with bits 31:24 zero. It appears on `rd_data` in the cycle after `rd_en` and holds until the next read.
- R3: Each `rd_en` while entries are held returns the oldest entry and removes it.
- R4: After every clock edge, `sts_full` (status bit 3) and `sts_nempty` (status bit 2) reflect the number of entries held after that edge.
- R5: A packet strobe while the queue is full and no read is made is discarded, and the stored entries are left unchanged. It sets `irq_ovf`, which stays high until an `ovf_clr` cycle that has no new drop; a drop wins over a clear in the same cycle.
- R6: A read while the queue is empty makes `rd_data` zero and removes nothing.
- R7: `irq_nempty` rises one cycle after the queue becomes non-empty. An `nempty_clr` cycle forces it low after that edge, and it is raised again on the following edge if entries are still held.
- R8: A packet strobe and a read in the same cycle on a non-empty queue are both honoured, and the entry count is unchanged, including when the queue is full.
- R9: `soft_rst` empties the queue and clears `sts_full`, `sts_nempty`, both events and `rd_data` after the edge.
- R10: The synchronous reset `rst` leaves the block in the same state as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software-driven queue flush |
| pkt_vld | input | 1 | Short packet strobe |
| pkt_dt | input | 6 | Data type of the packet |
| pkt_vc | input | 2 | Virtual channel of the packet |
| pkt_data | input | 16 | Data field of the packet |
| rd_en | input | 1 | Read of the data register (pops one entry) |
| rd_data | output | 32 | Read word |
| sts_full | output | 1 | Queue full status |
| sts_nempty | output | 1 | Queue not-empty status |
| nempty_clr | input | 1 | Software clear of the not-empty event |
| irq_nempty | output | 1 | Not-empty event to the interrupt block |
| ovf_clr | input | 1 | Software clear of the overflow event |
| irq_ovf | output | 1 | Sticky overflow event to the interrupt block |

## Verification
The bench builds the queue with DEPTH set to 7. Seven entries is not a power of two, so the explicit pointer wrap is used, and the bench passes through the full, overflow, wrap and empty states many times in a few hundred cycles. Several sweeps with different write and read rates, combined with periodic event clears, cover simultaneous push and pop at both full and empty. They also cover clear-and-check drain loops and flushes in the middle of a stream. A queue model inside the bench predicts every output on every cycle.

// File: rtl/spkt_pkg.sv
package spkt_pkg;
  localparam int DT_W   = 6;
  localparam int VC_W   = 2;
  localparam int PL_W   = 16;
  localparam int ENT_W  = PL_W + VC_W + DT_W;
  localparam int WORD_W = 32;

  // field order sets the read-word layout: payload 23:8, vc 7:6, dt 5:0
  typedef struct packed {
    logic [PL_W-1:0] pl;
    logic [VC_W-1:0] vc;
    logic [DT_W-1:0] dt;
  } spkt_ent_t;
endpackage

// File: rtl/spkt_store.sv
module spkt_store #(
  parameter int DEPTH = 31,
  parameter int AW    = 5,
  parameter int W     = 24
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_q
);
  logic [W-1:0] mem [DEPTH];

  // simple dual port, registered read, read-first on address collision
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/spkt_ctrl.sv
module spkt_ctrl #(
  parameter int DEPTH = 31,
  parameter int AW    = 5,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          pkt_vld,
  input  logic          rd_en,
  output logic          push,
  output logic          pop,
  output logic          drop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          hit_q,
  output logic          full_q,
  output logic          nempty_q
);
  localparam bit POW2 = ((1 << AW) == DEPTH);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [AW-1:0] wptr_inc, rptr_inc;
  logic          at_full, at_empty;

  assign at_full  = (cnt_q == CW'(DEPTH));
  assign at_empty = (cnt_q == '0);
  assign pop      = rd_en & ~at_empty;
  assign push     = pkt_vld & (~at_full | pop);
  assign drop     = pkt_vld & ~push;
  assign cnt_nxt  = cnt_q + CW'(push) - CW'(pop);

  generate
    if (POW2) begin : g_wrap_nat
      assign wptr_inc = wptr + AW'(1);
      assign rptr_inc = rptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wptr_inc = (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      assign rptr_inc = (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      wptr     <= '0;
      rptr     <= '0;
      hit_q    <= 1'b0;
      full_q   <= 1'b0;
      nempty_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      if (push) wptr <= wptr_inc;
      if (pop)  rptr <= rptr_inc;
      if (rd_en) hit_q <= pop;
      full_q   <= (cnt_nxt == CW'(DEPTH));
      nempty_q <= (cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/spkt_evt.sv
module spkt_evt (
  input  logic clk,
  input  logic clr,
  input  logic nempty_i,
  input  logic drop_i,
  input  logic nempty_clr,
  input  logic ovf_clr,
  output logic irq_nempty,
  output logic irq_ovf
);
  always_ff @(posedge clk) begin
    if (clr) begin
      irq_nempty <= 1'b0;
      irq_ovf    <= 1'b0;
    end else begin
      // a clear lowers the event for one edge; held entries raise it again
      if (nempty_clr)    irq_nempty <= 1'b0;
      else if (nempty_i) irq_nempty <= 1'b1;
      if (drop_i)        irq_ovf <= 1'b1;
      else if (ovf_clr)  irq_ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spkt_queue.sv
module spkt_queue
  import spkt_pkg::*;
#(
  parameter int DEPTH = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        soft_rst,
  input  logic        pkt_vld,
  input  logic [5:0]  pkt_dt,
  input  logic [1:0]  pkt_vc,
  input  logic [15:0] pkt_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        sts_full,
  output logic        sts_nempty,
  input  logic        nempty_clr,
  output logic        irq_nempty,
  input  logic        ovf_clr,
  output logic        irq_ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clr, push, pop, drop, hit_q;
  logic [AW-1:0] wptr, rptr;
  spkt_ent_t     wr_ent, rd_ent;

  assign clr    = rst | soft_rst;
  assign wr_ent = '{pl: pkt_data, vc: pkt_vc, dt: pkt_dt};

  spkt_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_ctrl (
    .clk(clk), .clr(clr), .pkt_vld(pkt_vld), .rd_en(rd_en),
    .push(push), .pop(pop), .drop(drop), .wptr(wptr), .rptr(rptr),
    .hit_q(hit_q), .full_q(sts_full), .nempty_q(sts_nempty)
  );

  spkt_store #(.DEPTH(DEPTH), .AW(AW), .W(ENT_W)) i_store (
    .clk(clk), .wr_en(push), .wr_addr(wptr), .wr_data(wr_ent),
    .rd_en(pop), .rd_addr(rptr), .rd_q(rd_ent)
  );

  spkt_evt i_evt (
    .clk(clk), .clr(clr), .nempty_i(sts_nempty), .drop_i(drop),
    .nempty_clr(nempty_clr), .ovf_clr(ovf_clr),
    .irq_nempty(irq_nempty), .irq_ovf(irq_ovf)
  );

  assign rd_data = hit_q ? {{(WORD_W-ENT_W){1'b0}}, rd_ent} : '0;
endmodule

// File: rtl/spkt_queue_chk.sv
module spkt_queue_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic        pkt_vld,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic        sts_full,
  input logic        sts_nempty,
  input logic        nempty_clr,
  input logic        irq_nempty,
  input logic        irq_ovf
);
  assert_full_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    sts_full |-> sts_nempty);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && sts_full && !rd_en && !soft_rst) |=> (irq_ovf && sts_full));

  assert_push_pop_full_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && rd_en && sts_full && !soft_rst) |=> sts_full);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sts_nempty && !pkt_vld && !soft_rst) |=> (!sts_nempty && rd_data == 32'd0));

  assert_clear_drops_event_R7: assert property (@(posedge clk) disable iff (rst)
    (nempty_clr && !soft_rst) |=> !irq_nempty);

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!sts_nempty && !sts_full && !irq_ovf && !irq_nempty && rd_data == 32'd0));

  assert_word_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:24] == 8'd0);
endmodule

bind spkt_queue spkt_queue_chk i_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .pkt_vld(pkt_vld), .rd_en(rd_en),
  .rd_data(rd_data), .sts_full(sts_full), .sts_nempty(sts_nempty),
  .nempty_clr(nempty_clr), .irq_nempty(irq_nempty), .irq_ovf(irq_ovf)
);

// File: tb/test_spkt_queue.sv
module test_spkt_queue;
  localparam int CLK_PERIOD = 10;
  localparam int D = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        pkt_vld = 1'b0;
  logic [5:0]  pkt_dt = '0;
  logic [1:0]  pkt_vc = '0;
  logic [15:0] pkt_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        sts_full, sts_nempty;
  logic        nempty_clr = 1'b0;
  logic        irq_nempty;
  logic        ovf_clr = 1'b0;
  logic        irq_ovf;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [23:0] mq[$];
  logic [31:0] m_rd = '0;
  bit m_pend = 0;
  bit m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spkt_queue #(.DEPTH(D)) i_spkt_queue (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .pkt_vld(pkt_vld),
    .pkt_dt(pkt_dt), .pkt_vc(pkt_vc), .pkt_data(pkt_data), .rd_en(rd_en),
    .rd_data(rd_data), .sts_full(sts_full), .sts_nempty(sts_nempty),
    .nempty_clr(nempty_clr), .irq_nempty(irq_nempty), .ovf_clr(ovf_clr),
    .irq_ovf(irq_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ent(input int k);
    logic [15:0] d;
    logic [1:0]  v;
    logic [5:0]  t;
    d = 16'((k * 613 + 29) & 16'hFFFF);
    v = 2'(k & 3);
    t = 6'((k * 5 + 1) & 6'h3F);
    return {d, v, t};
  endfunction

  task automatic compare_all();
    chk("R3 rd_data", rd_data, m_rd);
    chk("R4 full", {31'd0, sts_full}, {31'd0, mq.size() == D});
    chk("R4 nempty", {31'd0, sts_nempty}, {31'd0, mq.size() != 0});
    chk("R7 irq_nempty", {31'd0, irq_nempty}, {31'd0, m_pend});
    chk("R5 irq_ovf", {31'd0, irq_ovf}, {31'd0, m_ovf});
  endtask

  task automatic tick(input bit v, input logic [23:0] e, input bit r,
                      input bit nc, input bit oc, input bit sr);
    int  sz;
    bit  hit, acc;
    pkt_vld = v; {pkt_data, pkt_vc, pkt_dt} = e; rd_en = r;
    nempty_clr = nc; ovf_clr = oc; soft_rst = sr;
    @(posedge clk); #1;
    sz = mq.size();
    if (sr) begin
      mq.delete(); m_rd = '0; m_pend = 0; m_ovf = 0;
    end else begin
      hit = r && (sz > 0);
      acc = v && ((sz < D) || hit);
      m_pend = nc ? 1'b0 : (m_pend | (sz > 0));
      if (r) m_rd = hit ? {8'd0, mq.pop_front()} : 32'd0;
      if (acc) mq.push_back(e);
      m_ovf = (v && !acc) ? 1'b1 : (oc ? 1'b0 : m_ovf);
    end
    pkt_vld = 0; rd_en = 0; nempty_clr = 0; ovf_clr = 0; soft_rst = 0;
    compare_all();
  endtask

  task automatic hard_reset();
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    mq.delete(); m_rd = '0; m_pend = 0; m_ovf = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    hard_reset();
    // R10: reset state
    chk("R10 rd_data", rd_data, 32'd0);
    chk("R10 flags", {28'd0, sts_full, sts_nempty, irq_nempty, irq_ovf}, 32'd0);

    // R2: field placement of one known packet, then hold without a read
    tick(1, {16'hA5C3, 2'd2, 6'h2A}, 0, 0, 0, 0);
    tick(0, '0, 1, 0, 0, 0);
    chk("R2 layout", rd_data, 32'h00A5C3AA);
    tick(0, '0, 0, 0, 0, 0);
    chk("R2 hold", rd_data, 32'h00A5C3AA);

    // R6: read while empty
    tick(0, '0, 1, 0, 0, 0);
    chk("R6 empty read", rd_data, 32'd0);
    chk("R6 still empty", {31'd0, sts_nempty}, 32'd0);

    // R1: fill to exactly DEPTH
    for (int k = 0; k < D; k++) begin
      tick(1, ent(k), 0, 0, 0, 0);
      chk("R1 full only at depth", {31'd0, sts_full}, {31'd0, k == D-1});
    end

    // R5: drops while full; clear in same cycle as a drop loses
    tick(1, ent(100), 0, 0, 0, 0);
    chk("R5 ovf set", {31'd0, irq_ovf}, 32'd1);
    tick(1, ent(101), 0, 0, 1, 0);
    chk("R5 drop beats clear", {31'd0, irq_ovf}, 32'd1);

    // R8: push and pop together while full
    tick(1, ent(200), 1, 0, 0, 0);
    chk("R8 full kept", {31'd0, sts_full}, 32'd1);
    chk("R8 oldest out", rd_data, {8'd0, ent(0)});

    // R7: clear with entries held, then re-raise
    tick(0, '0, 0, 1, 0, 0);
    chk("R7 low after clear", {31'd0, irq_nempty}, 32'd0);
    tick(0, '0, 0, 0, 0, 0);
    chk("R7 raised again", {31'd0, irq_nempty}, 32'd1);

    // clear-and-check drain loop
    for (int k = 0; k < D + 2; k++) tick(0, '0, 1, 1, 0, 0);
    tick(0, '0, 0, 0, 1, 0);
    chk("R5 ovf cleared", {31'd0, irq_ovf}, 32'd0);
    chk("R7 stays low when empty", {31'd0, irq_nempty}, 32'd0);

    // sweeps at varied write/read rates
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 200; k++) begin
        tick((k % 3) != (p % 3), ent(k + 1000 * p), ((k + p) % 4) < p + 1 - (p == 0 ? 0 : 1) + (p == 0 ? 0 : 0),
             (k % 5) == 0, (k % 11) == 0, (p == 2) && (k == 100));
      end
      if (p == 0) chk("R1 sweep reached full", {31'd0, sts_full}, 32'd1);
    end

    // R9: flush a loaded queue
    for (int k = 0; k < 4; k++) tick(1, ent(k + 5000), 0, 0, 0, 0);
    tick(1, ent(5999), 0, 0, 0, 1);
    chk("R9 emptied", {30'd0, sts_nempty, sts_full}, 32'd0);
    tick(0, '0, 1, 0, 0, 0);
    chk("R9 nothing left", rd_data, 32'd0);

    // R10: reset of a loaded queue
    for (int k = 0; k < D + 1; k++) tick(1, ent(k + 7000), 0, 0, 0, 0);
    tick(0, '0, 1, 0, 0, 0);
    hard_reset();
    chk("R10 cleared", {28'd0, sts_full, sts_nempty, irq_nempty, irq_ovf}, 32'd0);
    chk("R10 rd_data", rd_data, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule